// File: doc/BRIEF.md
# Programmable Interval Timer

The block counts down input tick pulses and raises an interrupt each time the count runs out. A host loads a reload value into a holding register. Each tick pulse that arrives while the timer runs lowers a down-counter by one. When the counter runs out, the timer sets a sticky interrupt flag. An enable bit decides whether that flag drives the interrupt line.

The timer has two reload policies. In one-shot mode the counter stops at zero and ignores further ticks until software writes the holding register again. In periodic mode the counter is refilled from the holding register on the same tick that exhausts it. Each refill also flips a square-wave output, so a reload value of N gives a wave with a period of 2N ticks. A reload value of zero counts as the full counter range, 2^W ticks. The host reaches the block through a simple write strobe and a combinational read port.

Register selects: 0 control, 1 holding, 2 status, 3 live count (read only).

Top module: `interval_timer`

## Requirements
- R1: A write to the holding register (select 1) while the run bit is clear copies the written value into the counter. The new value can be read at select 3 after the write.
- R2: While the run bit (control bit 0) is set, each clock cycle with tick high lowers a nonzero, non-final count by exactly one. While the run bit is clear, ticks leave the count unchanged.
- R3: When the count runs out, status bit 0 is set. It stays set until the host writes 1 to status bit 0. If a set and a clear fall in the same cycle, the set wins.
- R4: The interrupt output equals the status flag gated by the interrupt-enable bit (control bit 2). The flag is still recorded while that bit is clear.
- R5: In one-shot mode (control bit 1 clear), the count goes from 1 to 0 and then holds at 0 whatever ticks arrive. A holding-register write in this expired state reloads the counter and restarts it.
- R6: In periodic mode (control bit 1 set), a tick at count 1 loads the holding value into the counter in the same cycle and inverts the square-wave output. No other event changes that output.
- R7: A holding-register write while the timer runs and is counting (periodic mode, or one-shot and not yet expired) leaves the live count unchanged. The new value is used at the next automatic reload.
- R8: A reload value of 0 gives a period of 2^W ticks. The first tick takes the count to 2^W-1, and the interrupt comes on tick 2^W.
- R9: After reset, control, holding, count, the flag, the interrupt line and the square-wave output are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count pulse, one per clock cycle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for writes |
| wr_data | input | W | Write data |
| rd_addr | input | 2 | Register select for reads |
| rd_data | output | W | Read data, combinational |
| irq | output | 1 | Masked interrupt line |
| sq_out | output | 1 | Periodic-mode square wave |

## Verification
The bench checks the exact tick on which each interrupt rises, for every reload, against a queue of expected tick indices. An off-by-one reload would shift those indices, and a design that reloads at zero rather than on the final tick would stretch each period by one. It checks that a one-shot counter stays at zero under extra ticks; a design that wraps would show 2^W-1 there. It checks that a holding write during a run does not change the live count, and that a zero reload takes the full range. It also checks that a masked interrupt still sets the flag, and that a disabled timer ignores ticks.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_HOLD  = 2'd1,
        SEL_STAT  = 2'd2,
        SEL_COUNT = 2'd3
    } reg_sel_e;

    // control register layout, bit 0 = run, bit 1 = periodic, bit 2 = irq enable
    typedef struct packed {
        logic irq_en;
        logic periodic;
        logic run;
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);

    function automatic ctrl_t to_ctrl(input logic [CTRL_BITS-1:0] raw);
        return ctrl_t'(raw);
    endfunction

endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    input  logic [W-1:0] count,
    input  logic         armed,
    input  logic         flag,
    output ctrl_t        ctrl,
    output logic [W-1:0] hold,
    output logic         load,
    output logic         clr,
    output logic [W-1:0] rd_data
);
    localparam int PAD = W - CTRL_BITS;

    ctrl_t    ctrl_q;
    logic [W-1:0] hold_q;
    reg_sel_e wsel;
    reg_sel_e rsel;
    logic     hold_wr;

    assign wsel    = reg_sel_e'(wr_addr);
    assign rsel    = reg_sel_e'(rd_addr);
    assign hold_wr = wr_en && (wsel == SEL_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            hold_q <= '0;
        end else if (wr_en) begin
            if (wsel == SEL_CTRL) ctrl_q <= to_ctrl(wr_data[CTRL_BITS-1:0]);
            if (wsel == SEL_HOLD) hold_q <= wr_data;
        end
    end

    // direct counter load: stopped timer or expired one-shot
    assign load = hold_wr && (!ctrl_q.run || (!ctrl_q.periodic && !armed));
    assign clr  = wr_en && (wsel == SEL_STAT) && wr_data[0];

    always_comb begin
        unique case (rsel)
            SEL_CTRL:  rd_data = {{PAD{1'b0}}, ctrl_q};
            SEL_HOLD:  rd_data = hold_q;
            SEL_STAT:  rd_data = {{(W-1){1'b0}}, flag};
            default:   rd_data = count;
        endcase
    end

    assign ctrl = ctrl_q;
    assign hold = hold_q;

    // R1
    hold_load_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_wr && !ctrl_q.run) |-> load);

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    input  logic         periodic,
    input  logic [W-1:0] hold,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         armed,
    output logic         hit
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q, cnt_n;
    logic         arm_q, arm_n;
    logic         step;

    assign step = run && tick;

    always_comb begin
        cnt_n = cnt_q;
        arm_n = arm_q;
        hit   = 1'b0;
        if (load) begin
            cnt_n = load_val;
            arm_n = 1'b1;
        end else if (step && (periodic || arm_q)) begin
            if (cnt_q == ONE) begin
                hit   = 1'b1;
                cnt_n = periodic ? hold : '0;
                arm_n = periodic;
            end else begin
                cnt_n = cnt_q - ONE; // 0 wraps: zero means full range
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            arm_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            arm_q <= arm_n;
        end
    end

    assign count = cnt_q;
    assign armed = arm_q;

    // R2
    count_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && step && (periodic || arm_q) && cnt_q != ONE)
        |=> cnt_q == $past(cnt_q) - ONE);

    // R2
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !run) |=> $stable(cnt_q));

    // R5
    oneshot_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !periodic && !arm_q) |=> (cnt_q == $past(cnt_q)));

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && step && periodic && cnt_q == ONE) |=> cnt_q == $past(hold));

endmodule

// File: rtl/itmr_event.sv
module itmr_event (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic periodic,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq,
    output logic sq_out
);
    logic flag_q;
    logic sq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            sq_q   <= 1'b0;
        end else begin
            if (hit)      flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
            if (hit && periodic) sq_q <= ~sq_q;
        end
    end

    assign flag   = flag_q;
    assign irq    = flag_q && irq_en;
    assign sq_out = sq_q;

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);

    // R6
    sq_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && periodic) |=> sq_q != $past(sq_q));

    // R6
    sq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(sq_q));

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    output logic [W-1:0] rd_data,
    output logic         irq,
    output logic         sq_out
);
    ctrl_t        ctrl;
    logic [W-1:0] hold;
    logic [W-1:0] count;
    logic         load, clr, armed, hit, flag;

    itmr_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .count(count),
        .armed(armed), .flag(flag), .ctrl(ctrl), .hold(hold),
        .load(load), .clr(clr), .rd_data(rd_data)
    );

    itmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .run(ctrl.run),
        .periodic(ctrl.periodic), .hold(hold), .load(load),
        .load_val(wr_data), .count(count), .armed(armed), .hit(hit)
    );

    itmr_event u_evt (
        .clk(clk), .rst(rst), .hit(hit), .periodic(ctrl.periodic),
        .clr(clr), .irq_en(ctrl.irq_en), .flag(flag), .irq(irq),
        .sq_out(sq_out)
    );

    // R4
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.irq_en) |-> !irq);

endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic         irq, sq_out;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;
    int exp_q[$];
    logic irq_prev = 1'b0;
    bit done = 0;

    always #2.5 clk = ~clk;

    interval_timer #(.W(W)) i_interval_timer (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .sq_out(sq_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        @(negedge clk); rd_addr = a; #0.5; d = int'(rd_data);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1; tick_cnt++;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    // driver side of the scoreboard: expected interrupt tick index
    task automatic expect_irq_after(input int n);
        exp_q.push_back(tick_cnt + n);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // monitor side: each interrupt rise is matched against the queue
    always @(posedge clk) begin
        #1;
        if (!rst && irq && !irq_prev) begin
            if (exp_q.size() == 0) chk("R3 unexpected irq", tick_cnt, -1);
            else chk("R3 irq tick index", tick_cnt, exp_q.pop_front());
        end
        irq_prev = irq;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd(2'd3, v); chk("R9 count", v, 0);
        rd(2'd0, v); chk("R9 ctrl", v, 0);
        rd(2'd1, v); chk("R9 hold", v, 0);
        rd(2'd2, v); chk("R9 flag", v, 0);
        chk("R9 irq", int'(irq), 0);
        chk("R9 sq_out", int'(sq_out), 0);

        // R1 load while stopped, R2 ticks ignored while stopped
        wr(2'd1, 8'd5);
        rd(2'd3, v); chk("R1 count after load", v, 5);
        pulse(2);
        rd(2'd3, v); chk("R2 stopped count", v, 5);

        // one-shot, interrupt enabled
        wr(2'd0, 8'd5);
        expect_irq_after(5);
        pulse(4);
        rd(2'd3, v); chk("R2 decrement", v, 1);
        chk("R3 irq before end", int'(irq), 0);
        pulse(1);
        rd(2'd3, v); chk("R5 reached zero", v, 0);
        chk("R3 irq at end", int'(irq), 1);
        pulse(3);
        rd(2'd3, v); chk("R5 holds at zero", v, 0);
        rd(2'd2, v); chk("R3 flag sticky", v, 1);
        wr(2'd2, 8'd1);
        rd(2'd2, v); chk("R3 flag cleared", v, 0);
        chk("R3 irq cleared", int'(irq), 0);

        // R5 software restart while enabled and expired
        wr(2'd1, 8'd3);
        rd(2'd3, v); chk("R5 restart load", v, 3);
        wr(2'd0, 8'd1);
        pulse(3);
        rd(2'd2, v); chk("R4 flag while masked", v, 1);
        chk("R4 irq masked", int'(irq), 0);
        wr(2'd2, 8'd1);
        wr(2'd0, 8'd5);

        // R7 one-shot running: holding write does not touch count
        wr(2'd1, 8'd4);
        pulse(1);
        wr(2'd1, 8'd9);
        rd(2'd3, v); chk("R7 one-shot count kept", v, 3);
        expect_irq_after(3);
        pulse(3);
        wr(2'd2, 8'd1);

        // R6 periodic mode
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd3);
        wr(2'd0, 8'd7);
        expect_irq_after(3);
        pulse(3);
        rd(2'd3, v); chk("R6 reload value", v, 3);
        chk("R6 sq first toggle", int'(sq_out), 1);
        wr(2'd2, 8'd1);
        expect_irq_after(3);
        pulse(2);
        chk("R6 sq steady", int'(sq_out), 1);
        pulse(1);
        chk("R6 sq second toggle", int'(sq_out), 0);
        wr(2'd2, 8'd1);

        // R7 periodic: write takes effect at next reload
        pulse(1);
        wr(2'd1, 8'd5);
        rd(2'd3, v); chk("R7 periodic count kept", v, 2);
        expect_irq_after(2);
        pulse(2);
        rd(2'd3, v); chk("R7 new reload used", v, 5);
        chk("R6 sq third toggle", int'(sq_out), 1);
        wr(2'd2, 8'd1);

        // R8 zero reload = full range, one-shot
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd0);
        wr(2'd0, 8'd5);
        pulse(1);
        rd(2'd3, v); chk("R8 wrap from zero", v, 255);
        pulse(254);
        rd(2'd3, v); chk("R8 one left", v, 1);
        chk("R8 no early irq", int'(irq), 0);
        expect_irq_after(1);
        pulse(1);
        chk("R8 irq at full range", int'(irq), 1);
        wr(2'd2, 8'd1);

        repeat (3) @(negedge clk);
        chk("R3 all expected irqs seen", exp_q.size(), 0);
        finish_run();
    end
endmodule